// File: doc/BRIEF.md
# Serial FIFO Status and Interrupt Monitor

This block sits beside the transmit and receive FIFOs of a serial controller and turns their fill levels and access strobes into a status word, a raw interrupt vector, a masked interrupt vector and a single interrupt line. It does not hold any FIFO data. It samples the FIFO levels, the transmit push strobe, the receive push and pop strobes and a busy flag from the serial engine. It records the error events, a push into a full FIFO or a pop from an empty one, in sticky bits that stay set until software clears them.

Software reaches the block through a small register port with a single-cycle write strobe and a combinational read. It programs the two FIFO thresholds and the interrupt mask, and it clears error events through a write-only clear register. The bit order of the clear register differs from the bit order of the interrupt vector, and bit 0 of the clear register clears every error event at once. A threshold register keeps its old value when software writes a value at or above the FIFO depth. Software can therefore find the depth by writing increasing values and checking when the read-back stops following them.

Top module: `xfer_fifo_status`

## Requirements
- R1: Address 0x0 reads the status word. Bit 4 is 1 when the receive level equals DEPTH, bit 3 when the receive level is 0, bit 2 when the transmit level is 0, bit 1 when the transmit level equals DEPTH, and bit 0 follows the busy input.
- R2: Address 0x1 reads the current transmit level and address 0x2 reads the current receive level, both zero-extended.
- R3: The transmit threshold (address 0x3) and the receive threshold (address 0x4) reset to 0. A write stores its value only if the value is below DEPTH. A write of DEPTH or more leaves the stored value unchanged.
- R4: Interrupt vector bit 0 is 1 while the transmit level is at or below the transmit threshold. Bit 4 is 1 while the receive level is above the receive threshold. Both bits follow the current levels with no delay.
- R5: A transmit push while the transmit level equals DEPTH sets vector bit 1 from the next cycle on. The bit stays set until software clears it.
- R6: A receive pop while the receive level is 0 sets vector bit 2. A receive push while the receive level equals DEPTH sets vector bit 3. Both bits set from the next cycle on and stay set until cleared.
- R7: A write to address 0x8 clears error bits from the next cycle on. Write-data bit 1 clears vector bit 2, bit 2 clears vector bit 3, bit 3 clears vector bit 1, and bit 0 clears all three. Address 0x8 reads as 0.
- R8: When an error event and a clear of the same bit fall in the same cycle, the bit is set in the next cycle.
- R9: The mask (address 0x5, bits 4:0) resets to 0. Address 0x6 reads the raw vector, and address 0x7 reads the raw vector ANDed with the mask.
- R10: irq_o is 1 exactly when at least one bit of the masked vector is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Serial engine busy flag |
| tx_level_i | input | LVL_W | Number of entries in the transmit FIFO |
| rx_level_i | input | LVL_W | Number of entries in the receive FIFO |
| tx_push_i | input | 1 | Write strobe into the transmit FIFO |
| rx_push_i | input | 1 | Write strobe into the receive FIFO |
| rx_pop_i | input | 1 | Read strobe from the receive FIFO |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can hit one error bit in the same cycle: the detection of an error event and a software clear of that same bit through the clear register. The bench provokes this directly. It pushes into a full transmit FIFO while it writes the clear code for that bit. The random phase also mixes clear-register writes with push and pop strobes at the extreme fill levels, so overlaps of every kind occur. A reference model in the bench applies the clear first and the set second. The bench compares the raw vector and the interrupt line against that model in the cycle after the collision.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    localparam int ADDR_W = 4;
    localparam int IRQ_N  = 5;
    localparam int ERR_N  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 4'h0,
        A_TXLVL  = 4'h1,
        A_RXLVL  = 4'h2,
        A_TXTHR  = 4'h3,
        A_RXTHR  = 4'h4,
        A_MASK   = 4'h5,
        A_RAW    = 4'h6,
        A_MSKD   = 4'h7,
        A_CLEAR  = 4'h8
    } reg_addr_e;

    // positions in the interrupt vector
    localparam int IV_TX_LOW  = 0;
    localparam int IV_TX_OVF  = 1;
    localparam int IV_RX_UNF  = 2;
    localparam int IV_RX_OVF  = 3;
    localparam int IV_RX_HIGH = 4;

    // positions in the clear write data
    localparam int CL_ALL    = 0;
    localparam int CL_RX_UNF = 1;
    localparam int CL_RX_OVF = 2;
    localparam int CL_TX_OVF = 3;

    // index of each sticky error inside the error array
    localparam int EI_TX_OVF = 0;
    localparam int EI_RX_UNF = 1;
    localparam int EI_RX_OVF = 2;

endpackage

// File: rtl/xfs_sticky_bit.sv
module xfs_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        // a new event outranks a clear arriving in the same cycle
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/xfs_cfg_regs.sv
module xfs_cfg_regs
    import xfs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic [LVL_W-1:0]  rx_thr_o,
    output logic [IRQ_N-1:0]  mask_o
);

    typedef struct packed {
        logic [LVL_W-1:0] tx_thr;
        logic [LVL_W-1:0] rx_thr;
        logic [IRQ_N-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic in_range;

    always_comb begin
        cfg_d    = cfg_q;
        in_range = (int'(wdata_i) < DEPTH);
        if (we_i) begin
            unique case (addr_i)
                A_TXTHR: if (in_range) cfg_d.tx_thr = wdata_i[LVL_W-1:0];
                A_RXTHR: if (in_range) cfg_d.rx_thr = wdata_i[LVL_W-1:0];
                A_MASK:  cfg_d.mask = wdata_i[IRQ_N-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign tx_thr_o = cfg_q.tx_thr;
    assign rx_thr_o = cfg_q.rx_thr;
    assign mask_o   = cfg_q.mask;

endmodule

// File: rtl/xfer_fifo_status.sv
module xfer_fifo_status
    import xfs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic              tx_push_i,
    input  logic              rx_push_i,
    input  logic              rx_pop_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] cfg_txthr, cfg_rxthr;
    logic [IRQ_N-1:0] cfg_mask;
    logic [ERR_N-1:0] err_set, err_clr, err_flag;
    logic [IRQ_N-1:0] raw_irq, msk_irq;
    logic [4:0]       status_w;
    logic             clr_wr;

    xfs_cfg_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .tx_thr_o (cfg_txthr),
        .rx_thr_o (cfg_rxthr),
        .mask_o   (cfg_mask)
    );

    always_comb begin
        clr_wr = reg_we_i && (reg_addr_i == A_CLEAR);
        err_set[EI_TX_OVF] = tx_push_i && (tx_level_i == FULL_LVL);
        err_set[EI_RX_UNF] = rx_pop_i  && (rx_level_i == '0);
        err_set[EI_RX_OVF] = rx_push_i && (rx_level_i == FULL_LVL);
        err_clr[EI_TX_OVF] = clr_wr && (reg_wdata_i[CL_ALL] || reg_wdata_i[CL_TX_OVF]);
        err_clr[EI_RX_UNF] = clr_wr && (reg_wdata_i[CL_ALL] || reg_wdata_i[CL_RX_UNF]);
        err_clr[EI_RX_OVF] = clr_wr && (reg_wdata_i[CL_ALL] || reg_wdata_i[CL_RX_OVF]);
    end

    for (genvar g = 0; g < ERR_N; g++) begin : g_err
        xfs_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (err_set[g]),
            .clr_i  (err_clr[g]),
            .flag_o (err_flag[g])
        );
    end

    always_comb begin
        raw_irq             = '0;
        raw_irq[IV_TX_LOW]  = (tx_level_i <= cfg_txthr);
        raw_irq[IV_TX_OVF]  = err_flag[EI_TX_OVF];
        raw_irq[IV_RX_UNF]  = err_flag[EI_RX_UNF];
        raw_irq[IV_RX_OVF]  = err_flag[EI_RX_OVF];
        raw_irq[IV_RX_HIGH] = (rx_level_i > cfg_rxthr);
        msk_irq             = raw_irq & cfg_mask;

        status_w = {rx_level_i == FULL_LVL, rx_level_i == '0,
                    tx_level_i == '0, tx_level_i == FULL_LVL, busy_i};
    end

    always_comb begin
        unique case (reg_addr_i)
            A_STATUS: reg_rdata_o = DATA_W'(status_w);
            A_TXLVL:  reg_rdata_o = DATA_W'(tx_level_i);
            A_RXLVL:  reg_rdata_o = DATA_W'(rx_level_i);
            A_TXTHR:  reg_rdata_o = DATA_W'(cfg_txthr);
            A_RXTHR:  reg_rdata_o = DATA_W'(cfg_rxthr);
            A_MASK:   reg_rdata_o = DATA_W'(cfg_mask);
            A_RAW:    reg_rdata_o = DATA_W'(raw_irq);
            A_MSKD:   reg_rdata_o = DATA_W'(msk_irq);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |msk_irq;

endmodule

// File: rtl/xfs_checker.sv
module xfs_checker
    import xfs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  tx_level_i,
    input logic [LVL_W-1:0]  rx_level_i,
    input logic              tx_push_i,
    input logic              rx_push_i,
    input logic              rx_pop_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [IRQ_N-1:0]  raw_irq,
    input logic [IRQ_N-1:0]  cfg_mask,
    input logic [LVL_W-1:0]  cfg_txthr,
    input logic [LVL_W-1:0]  cfg_rxthr,
    input logic              irq_o
);

    logic txo_clr;
    assign txo_clr = reg_we_i && (reg_addr_i == A_CLEAR) &&
                     (reg_wdata_i[CL_ALL] || reg_wdata_i[CL_TX_OVF]);

    AST_TXO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_i && int'(tx_level_i) == DEPTH) |=> raw_irq[IV_TX_OVF]); // R5

    AST_TXO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_irq[IV_TX_OVF] && !txo_clr) |=> raw_irq[IV_TX_OVF]); // R5

    AST_RXU_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_i && rx_level_i == '0) |=> raw_irq[IV_RX_UNF]); // R6

    AST_RXO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_i && int'(rx_level_i) == DEPTH) |=> raw_irq[IV_RX_OVF]); // R6

    AST_THR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_txthr) < DEPTH) && (int'(cfg_rxthr) < DEPTH)); // R3

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((raw_irq & cfg_mask) != '0)); // R10

endmodule

bind xfer_fifo_status xfs_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_level_i  (tx_level_i),
    .rx_level_i  (rx_level_i),
    .tx_push_i   (tx_push_i),
    .rx_push_i   (rx_push_i),
    .rx_pop_i    (rx_pop_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .raw_irq     (raw_irq),
    .cfg_mask    (cfg_mask),
    .cfg_txthr   (cfg_txthr),
    .cfg_rxthr   (cfg_rxthr),
    .irq_o       (irq_o)
);

// File: tb/sim_xfer_fifo_status.sv
module sim_xfer_fifo_status;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int DATA_W     = 8;
    localparam int LVL_W      = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              busy_i = 1'b0;
    logic [LVL_W-1:0]  tx_level_i = '0;
    logic [LVL_W-1:0]  rx_level_i = '0;
    logic              tx_push_i = 1'b0;
    logic              rx_push_i = 1'b0;
    logic              rx_pop_i = 1'b0;
    logic              reg_we_i = 1'b0;
    logic [3:0]        reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    int m_txthr, m_rxthr, m_mask;
    bit m_txo, m_rxu, m_rxo;

    xfer_fifo_status #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
        .tx_level_i(tx_level_i), .rx_level_i(rx_level_i),
        .tx_push_i(tx_push_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_raw();
        int txl = int'(tx_level_i);
        int rxl = int'(rx_level_i);
        return ((rxl > m_rxthr) ? 16 : 0) | (m_rxo ? 8 : 0) | (m_rxu ? 4 : 0)
             | (m_txo ? 2 : 0) | ((txl <= m_txthr) ? 1 : 0);
    endfunction

    function automatic int exp_rd(int a);
        int txl = int'(tx_level_i);
        int rxl = int'(rx_level_i);
        case (a)
            0: return ((rxl == DEPTH) ? 16 : 0) | ((rxl == 0) ? 8 : 0)
                    | ((txl == 0) ? 4 : 0) | ((txl == DEPTH) ? 2 : 0) | int'(busy_i);
            1: return txl;
            2: return rxl;
            3: return m_txthr;
            4: return m_rxthr;
            5: return m_mask;
            6: return exp_raw();
            7: return exp_raw() & m_mask;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R1";
            1, 2: return "R2";
            3, 4: return "R3";
            6: return "R4";
            5, 7: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(string tag, bit we, int addr, int wd, int txl, int rxl,
                         bit tpush, bit rpush, bit rpop, bit bsy);
        bit cl_all, cl_u, cl_o, cl_t;
        @(negedge clk);
        reg_we_i = we; reg_addr_i = 4'(addr); reg_wdata_i = DATA_W'(wd);
        tx_level_i = LVL_W'(txl); rx_level_i = LVL_W'(rxl);
        tx_push_i = tpush; rx_push_i = rpush; rx_pop_i = rpop; busy_i = bsy;
        #1;
        check((tag == "") ? tag_of(addr) : tag, int'(reg_rdata_o), exp_rd(addr));
        check("R10", int'(irq_o), ((exp_raw() & m_mask) != 0) ? 1 : 0);
        @(posedge clk);
        if (we) begin
            if (addr == 3 && wd < DEPTH) m_txthr = wd;
            if (addr == 4 && wd < DEPTH) m_rxthr = wd;
            if (addr == 5) m_mask = wd & 31;
        end
        cl_all = we && addr == 8 && wd[0];
        cl_u   = cl_all || (we && addr == 8 && wd[1]);
        cl_o   = cl_all || (we && addr == 8 && wd[2]);
        cl_t   = cl_all || (we && addr == 8 && wd[3]);
        m_txo = (m_txo && !cl_t) || (tpush && txl == DEPTH);
        m_rxu = (m_rxu && !cl_u) || (rpop && rxl == 0);
        m_rxo = (m_rxo && !cl_o) || (rpush && rxl == DEPTH);
    endtask

    function automatic int pick_level();
        int r = int'($urandom_range(0, 9));
        if (r < 3) return 0;
        if (r < 6) return DEPTH;
        return int'($urandom_range(0, DEPTH));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_txthr = 0; m_rxthr = 0; m_mask = 0; m_txo = 0; m_rxu = 0; m_rxo = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        cycle("R3", 0, 3, 0, 0, 0, 0, 0, 0, 0);
        cycle("R9", 0, 5, 0, 0, 0, 0, 0, 0, 0);
        cycle("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check("R10", int'(irq_o), 0);

        // threshold acceptance and rejection at the depth boundary
        cycle("R3", 1, 3, DEPTH-1, 3, 3, 0, 0, 0, 0);
        cycle("R3", 1, 3, DEPTH,   3, 3, 0, 0, 0, 0);
        cycle("R3", 1, 4, 5,       3, 3, 0, 0, 0, 0);
        cycle("R3", 1, 4, 200,     3, 3, 0, 0, 0, 0);
        cycle("R3", 0, 4, 0,       3, 3, 0, 0, 0, 0);
        check("R3", int'(reg_rdata_o), 5);
        cycle("R4", 0, 6, 0, DEPTH, 6, 0, 0, 0, 0);

        // sticky error bits
        cycle("R5", 0, 6, 0, DEPTH, 3, 1, 0, 0, 0);
        cycle("R5", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R5", int'(reg_rdata_o[1]), 1);
        cycle("R6", 0, 6, 0, 2, 0, 0, 0, 1, 0);
        cycle("R6", 0, 6, 0, 2, DEPTH, 0, 1, 0, 0);
        cycle("R6", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R6", int'(reg_rdata_o[3:1]), 7);

        // clear bit ordering
        cycle("R7", 1, 8, 2, 2, 3, 0, 0, 0, 0);
        cycle("R7", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R7", int'(reg_rdata_o[3:1]), 5);
        cycle("R7", 1, 8, 4, 2, 3, 0, 0, 0, 0);
        cycle("R7", 1, 8, 8, 2, 3, 0, 0, 0, 0);
        cycle("R7", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R7", int'(reg_rdata_o[3:1]), 0);
        cycle("R6", 0, 6, 0, 2, 0, 0, 0, 1, 0);
        cycle("R5", 0, 6, 0, DEPTH, DEPTH, 1, 1, 0, 0);
        cycle("R7", 1, 8, 1, 2, 3, 0, 0, 0, 0);
        cycle("R7", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R7", int'(reg_rdata_o[3:1]), 0);

        // event and clear of the same bit in one cycle
        cycle("R8", 1, 8, 8, DEPTH, 3, 1, 0, 0, 0);
        cycle("R8", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R8", int'(reg_rdata_o[1]), 1);
        cycle("R8", 1, 8, 1, 2, 0, 0, 0, 1, 0);
        cycle("R8", 0, 6, 0, 2, 3, 0, 0, 0, 0);
        check("R8", int'(reg_rdata_o[3:1]), 2);

        // mask and interrupt line
        cycle("R9", 1, 5, 4, 2, 3, 0, 0, 0, 0);
        cycle("R9", 0, 7, 0, 2, 3, 0, 0, 0, 0);
        check("R10", int'(irq_o), 1);
        cycle("R9", 1, 5, 8'hE2, 2, 3, 0, 0, 0, 0);
        cycle("R9", 0, 5, 0, 2, 3, 0, 0, 0, 0);
        check("R10", int'(irq_o), 0);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int a = int'($urandom_range(0, 8));
            bit we = ($urandom_range(0, 3) == 0);
            int wd = ($urandom_range(0, 3) == 0) ? DEPTH - 1 + int'($urandom_range(0, 1))
                                                : int'($urandom_range(0, 255));
            if (a == 8 && $urandom_range(0, 1) == 1) wd = wd & 15;
            cycle("", we, a, wd, pick_level(), pick_level(),
                  $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
                  $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule